// File: doc/BRIEF.md
# Banked Data Memory with Indirect Pointers

This block is the data-memory subsystem of a small 8-bit controller. One 8-bit address space holds two pointer registers, an accumulator, a reserved region that reads as zero, and a general-purpose RAM region. Two addresses in the map are not storage. Any read, write or bit operation aimed at one of them is redirected to the location named by its pointer register.

The block has a combinational read port and a clocked write port. The write port either stores a whole byte or sets or clears one bit of the resolved location in a single cycle. A configuration input selects full 8-bit pointers or 7-bit pointers. In 7-bit mode the top pointer bit is not kept and reads back as 1. The instruction decoder drives the direct addresses and the ALU consumes the read data.

Top module: `bank_data_mem`

## Requirements
- R1: After reset both pointers, the accumulator and every RAM byte hold 00H, so reads of 01H, 03H, 05H and any RAM address return 00H when `ptr7Mode` is 0.
- R2: General RAM starts at 28H and holds `RAM_BYTES` bytes (96 by default, so its top address is 87H). A byte write there lands on the clock edge, and `rdData` follows `rdAddr` combinationally.
- R3: The accumulator sits at 05H and can be written and read like any RAM byte.
- R4: Every address below 28H other than 00H to 03H and 05H, and every address above the top of RAM, reads as 00H and ignores all writes.
- R5: An access to 00H is redirected to the address held in pointer 0 (at 01H). An access to 02H is redirected to the address held in pointer 1 (at 03H). This holds for reads, byte writes and bit operations.
- R6: If a redirected access resolves to 00H or 02H, a read returns 00H and a byte or bit write changes nothing.
- R7: With `ptr7Mode` at 1, a pointer write stores only bits 6..0 and bit 7 is kept at 0. Pointer bit 7 reads as 1. The redirected address is the low 7 pointer bits with bit 7 cleared, so 80H and above cannot be reached indirectly.
- R8: `wrOp` = 2'b10 clears and `wrOp` = 2'b11 sets bit `wrBit` of the location resolved from `wrAddr`. The other seven bits are left unchanged.
- R9: `wrOp` = 2'b01 writes `wrData` to the resolved location. `wrOp` = 2'b00 changes no state, whatever `wrAddr` and `wrData` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ptr7Mode | input | 1 | 1 selects 7-bit pointers, 0 selects 8-bit pointers |
| rdAddr | input | 8 | Direct read address |
| rdData | output | 8 | Read data for `rdAddr`, combinational |
| wrOp | input | 2 | 00 none, 01 byte write, 10 bit clear, 11 bit set |
| wrAddr | input | 8 | Direct address for the write or bit operation |
| wrData | input | 8 | Byte to store when `wrOp` is 01 |
| wrBit | input | 3 | Bit index for a set or clear |

## Verification
A corrupted pointer shows up on `rdData` as soon as `rdAddr` is set to 00H or 02H. A read of 01H or 03H shows the stored pointer itself within the same cycle. A stale or wrong accumulator or RAM byte appears on the first combinational read of that address after the faulty write edge. A bit operation that disturbs its neighbour bits shows up in that same next read. Reserved holes and self-referencing indirect accesses must read zero in every cycle. A write that leaks into them would surface at once as a nonzero read.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_IND0 = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PTR0 = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_IND1 = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_PTR1 = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_ACC  = 8'h05;
  localparam logic [ADDR_W-1:0] RAM_BASE  = 8'h28;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_BYTE = 2'b01,
    OP_CLR  = 2'b10,
    OP_SET  = 2'b11
  } wrOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [ADDR_W-1:0] rdLoc;
    logic              rdNull;
    logic [ADDR_W-1:0] wrLoc;
    logic              wrByte;
    logic              wrBitOp;
    logic              bitVal;
    logic [2:0]        bitIdx;
  } memStrobe_t;
endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic              ptr7Mode,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        wrOp,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrBit,
  input  logic [DATA_W-1:0] ptr0Q,
  input  logic [DATA_W-1:0] ptr1Q,
  output memStrobe_t        strobe
);
  // returns {isNull, location}
  function automatic logic [ADDR_W:0] resolve(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] eff;
    logic              isNull;
    eff    = a;
    isNull = 1'b0;
    if (a == ADDR_IND0 || a == ADDR_IND1) begin
      eff = (a == ADDR_IND0) ? ptr0Q : ptr1Q;
      if (ptr7Mode) eff[ADDR_W-1] = 1'b0;
      isNull = (eff == ADDR_IND0) || (eff == ADDR_IND1);
    end
    return {isNull, eff};
  endfunction

  logic [ADDR_W:0] rdRes;
  logic [ADDR_W:0] wrRes;
  wrOp_e           opKind;

  always_comb begin
    opKind = wrOp_e'(wrOp);
    rdRes  = resolve(rdAddr);
    wrRes  = resolve(wrAddr);
    strobe.rdLoc   = rdRes[ADDR_W-1:0];
    strobe.rdNull  = rdRes[ADDR_W];
    strobe.wrLoc   = wrRes[ADDR_W-1:0];
    strobe.wrByte  = (opKind == OP_BYTE) && !wrRes[ADDR_W];
    strobe.wrBitOp = ((opKind == OP_SET) || (opKind == OP_CLR)) && !wrRes[ADDR_W];
    strobe.bitVal  = (opKind == OP_SET);
    strobe.bitIdx  = wrBit;
  end
endmodule

// File: rtl/dmem_dp.sv
module dmem_dp
  import dmem_pkg::*;
#(
  parameter int RAM_BYTES = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptr7Mode,
  input  memStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ptr0Q,
  output logic [DATA_W-1:0] ptr1Q,
  output logic [DATA_W-1:0] accQ
);
  localparam int RAM_TOP = int'(RAM_BASE) + RAM_BYTES - 1;
  localparam int IDX_W   = $clog2(RAM_BYTES);

  logic [DATA_W-1:0] ramQ [RAM_BYTES];
  logic [DATA_W-1:0] curWr;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] bitMask;
  logic              wrAny;
  logic [ADDR_W-1:0] wrOff;

  function automatic logic inRam(input logic [ADDR_W-1:0] loc);
    return (int'(loc) >= int'(RAM_BASE)) && (int'(loc) <= RAM_TOP);
  endfunction

  function automatic logic [DATA_W-1:0] fetch(input logic [ADDR_W-1:0] loc);
    logic [ADDR_W-1:0] off;
    off = loc - RAM_BASE;
    if (loc == ADDR_PTR0)     return ptr7Mode ? {1'b1, ptr0Q[DATA_W-2:0]} : ptr0Q;
    else if (loc == ADDR_PTR1) return ptr7Mode ? {1'b1, ptr1Q[DATA_W-2:0]} : ptr1Q;
    else if (loc == ADDR_ACC)  return accQ;
    else if (inRam(loc))       return ramQ[off[IDX_W-1:0]];
    else                       return '0;
  endfunction

  always_comb begin
    rdData  = strobe.rdNull ? '0 : fetch(strobe.rdLoc);
    curWr   = fetch(strobe.wrLoc);
    bitMask = DATA_W'(1) << strobe.bitIdx;
    if (strobe.wrByte)      newByte = wrData;
    else if (strobe.bitVal) newByte = curWr | bitMask;
    else                    newByte = curWr & ~bitMask;
    wrAny = strobe.wrByte | strobe.wrBitOp;
    wrOff = strobe.wrLoc - RAM_BASE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr0Q <= '0;
      ptr1Q <= '0;
      accQ  <= '0;
    end else if (wrAny) begin
      if (strobe.wrLoc == ADDR_PTR0)
        ptr0Q <= ptr7Mode ? {1'b0, newByte[DATA_W-2:0]} : newByte;
      if (strobe.wrLoc == ADDR_PTR1)
        ptr1Q <= ptr7Mode ? {1'b0, newByte[DATA_W-2:0]} : newByte;
      if (strobe.wrLoc == ADDR_ACC)
        accQ <= newByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) ramQ[i] <= '0;
    end else if (wrAny && inRam(strobe.wrLoc)) begin
      ramQ[wrOff[IDX_W-1:0]] <= newByte;
    end
  end
endmodule

// File: rtl/bank_data_mem.sv
module bank_data_mem #(
  parameter int RAM_BYTES = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ptr7Mode,
  input  logic [7:0] rdAddr,
  output logic [7:0] rdData,
  input  logic [1:0] wrOp,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] wrBit
);
  import dmem_pkg::*;

  memStrobe_t  strobe;
  logic [7:0]  ptr0Q;
  logic [7:0]  ptr1Q;
  logic [7:0]  accQ;

  dmem_ctrl ctrl_i (
    .ptr7Mode (ptr7Mode),
    .rdAddr   (rdAddr),
    .wrOp     (wrOp),
    .wrAddr   (wrAddr),
    .wrBit    (wrBit),
    .ptr0Q    (ptr0Q),
    .ptr1Q    (ptr1Q),
    .strobe   (strobe)
  );

  dmem_dp #(.RAM_BYTES(RAM_BYTES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ptr7Mode (ptr7Mode),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .ptr0Q    (ptr0Q),
    .ptr1Q    (ptr1Q),
    .accQ     (accQ)
  );
endmodule

// File: rtl/dmem_chk.sv
module dmem_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ptr7Mode,
  input logic [7:0] rdAddr,
  input logic [7:0] rdData,
  input logic [1:0] wrOp,
  input logic [7:0] wrAddr,
  input logic [7:0] wrData,
  input logic [2:0] wrBit,
  input logic [7:0] ptr0Q,
  input logic [7:0] ptr1Q,
  input logic [7:0] accQ
);
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 8'h04 || (rdAddr > 8'h05 && rdAddr < 8'h28)) |-> rdData == 8'h00);

  p_ptr_high_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ptr7Mode && (rdAddr == 8'h01 || rdAddr == 8'h03)) |-> rdData[7]);

  p_self_ref_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 8'h00 && ({ptr0Q[7] & !ptr7Mode, ptr0Q[6:0]} inside {8'h00, 8'h02}))
      |-> rdData == 8'h00);

  p_acc_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == 2'b01 && wrAddr == 8'h05) |=> accQ == $past(wrData));

  p_bit_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == 2'b11 && wrAddr == 8'h05) |=> accQ == ($past(accQ) | (8'd1 << $past(wrBit))));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == 2'b00) |=> ($stable(accQ) && $stable(ptr0Q) && $stable(ptr1Q)));
endmodule

bind bank_data_mem dmem_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ptr7Mode (ptr7Mode),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .wrOp     (wrOp),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .wrBit    (wrBit),
  .ptr0Q    (ptr0Q),
  .ptr1Q    (ptr1Q),
  .accQ     (accQ)
);

// File: tb/bank_data_mem_tb_top.sv
`timescale 1ns/1ps
module bank_data_mem_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ptr7Mode = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;
  logic [1:0] wrOp = 2'b00;
  logic [7:0] wrAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [2:0] wrBit = 3'd0;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  bank_data_mem #(.RAM_BYTES(96)) dut_i (
    .clk(clk), .rstN(rstN), .ptr7Mode(ptr7Mode),
    .rdAddr(rdAddr), .rdData(rdData),
    .wrOp(wrOp), .wrAddr(wrAddr), .wrData(wrData), .wrBit(wrBit)
  );

  task automatic doOp(input logic [1:0] op, input logic [7:0] a,
                      input logic [7:0] d, input logic [2:0] b);
    @(negedge clk);
    wrOp = op; wrAddr = a; wrData = d; wrBit = b;
    @(negedge clk);
    wrOp = 2'b00;
  endtask

  task automatic readChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rdAddr = a;
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s addr %02h: got %02h expected %02h", req, a, rdData, exp);
    end
  endtask

  task automatic testReset();   // R1
    readChk(8'h01, 8'h00, "R1");
    readChk(8'h03, 8'h00, "R1");
    readChk(8'h05, 8'h00, "R1");
    readChk(8'h28, 8'h00, "R1");
  endtask

  task automatic testRam();     // R2
    doOp(2'b01, 8'h28, 8'hA5, 3'd0);
    doOp(2'b01, 8'h87, 8'h3C, 3'd0);
    readChk(8'h28, 8'hA5, "R2");
    readChk(8'h87, 8'h3C, "R2");
  endtask

  task automatic testAcc();     // R3
    doOp(2'b01, 8'h05, 8'h5A, 3'd0);
    readChk(8'h05, 8'h5A, "R3");
  endtask

  task automatic testHoles();   // R4
    doOp(2'b01, 8'h10, 8'hFF, 3'd0);
    doOp(2'b01, 8'h88, 8'h55, 3'd0);
    doOp(2'b11, 8'h04, 8'h00, 3'd2);
    readChk(8'h10, 8'h00, "R4");
    readChk(8'h88, 8'h00, "R4");
    readChk(8'h04, 8'h00, "R4");
    readChk(8'h27, 8'h00, "R4");
  endtask

  task automatic testIndirect(); // R5
    doOp(2'b01, 8'h01, 8'h30, 3'd0);
    doOp(2'b01, 8'h00, 8'h77, 3'd0);
    readChk(8'h30, 8'h77, "R5");
    readChk(8'h00, 8'h77, "R5");
    doOp(2'b01, 8'h03, 8'h05, 3'd0);
    readChk(8'h02, 8'h5A, "R5");
    doOp(2'b01, 8'h02, 8'h11, 3'd0);
    readChk(8'h05, 8'h11, "R5");
  endtask

  task automatic testSelfRef(); // R6
    doOp(2'b01, 8'h01, 8'h00, 3'd0);
    readChk(8'h00, 8'h00, "R6");
    doOp(2'b01, 8'h00, 8'h99, 3'd0);
    readChk(8'h01, 8'h00, "R6");
    doOp(2'b01, 8'h01, 8'h02, 3'd0);
    doOp(2'b11, 8'h00, 8'h00, 3'd1);
    readChk(8'h00, 8'h00, "R6");
    readChk(8'h01, 8'h02, "R6");
    readChk(8'h03, 8'h05, "R6");
  endtask

  task automatic testPtr7();    // R7
    doOp(2'b01, 8'h01, 8'h30, 3'd0);
    ptr7Mode = 1'b1;
    doOp(2'b01, 8'h01, 8'hB0, 3'd0);
    readChk(8'h01, 8'hB0, "R7");
    readChk(8'h00, 8'h77, "R7");
    doOp(2'b01, 8'h03, 8'h85, 3'd0);
    readChk(8'h03, 8'h85, "R7");
    readChk(8'h02, 8'h11, "R7");
    @(negedge clk);
    ptr7Mode = 1'b0;
    readChk(8'h01, 8'h30, "R7");
    readChk(8'h03, 8'h05, "R7");
  endtask

  task automatic testBits();    // R8
    doOp(2'b10, 8'h05, 8'hFF, 3'd4);
    readChk(8'h05, 8'h01, "R8");
    doOp(2'b11, 8'h05, 8'h00, 3'd7);
    readChk(8'h05, 8'h81, "R8");
    doOp(2'b11, 8'h00, 8'h00, 3'd3);
    readChk(8'h30, 8'h7F, "R8");
    doOp(2'b10, 8'h00, 8'h00, 3'd6);
    readChk(8'h30, 8'h3F, "R8");
  endtask

  task automatic testIdle();    // R9
    doOp(2'b00, 8'h28, 8'h12, 3'd0);
    doOp(2'b00, 8'h05, 8'h34, 3'd0);
    doOp(2'b00, 8'h01, 8'h56, 3'd0);
    readChk(8'h28, 8'hA5, "R9");
    readChk(8'h05, 8'h81, "R9");
    readChk(8'h01, 8'h30, "R9");
    doOp(2'b01, 8'h29, 8'hC3, 3'd0);
    readChk(8'h29, 8'hC3, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRam();
    testAcc();
    testHoles();
    testIndirect();
    testSelfRef();
    testPtr7();
    testBits();
    testIdle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule